// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block passes an 18-bit word between two ports, A and B, over two independent paths: A-to-B and B-to-A. Each path has a storage element that works in one of two ways, chosen by its own latch-enable input. With the latch enable high, the element is transparent and the far-side output follows the near-side bus combinationally. With the latch enable low, the element holds its contents, and it reloads only when a falling transition of that path's strobe input is detected.

The block runs inside a synchronous design on one system clock, so a strobe's falling transition is found by comparing the strobe level at two consecutive system clock edges. Each port's output is given as a data vector plus a separate drive-enable bit. A pad wrapper can turn these into a tri-state pin if one is needed. The A-to-B drive enable is active high and the B-to-A drive enable is active low. A keeper register on each port's input stands in for bus-hold: while nothing external drives a port, the path reads the last value that was driven onto it.

Top module: `bidir_bus_xcvr`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals the effective A-side value in the same cycle, with no register in between. The effective A-side value is `a_in` when `a_ext_drv` is 1 and the A keeper otherwise.
- R2: While `ab_le` is 0 and no falling transition of `ab_clk` is detected, the A-to-B storage keeps its contents and `b_out` does not change.
- R3: While `ab_le` is 0, a falling transition of `ab_clk` is detected when `ab_clk` is 1 at one system clock edge and 0 at the next. At that second edge the storage loads the effective A-side value, and `b_out` shows that value from then on.
- R4: When `ab_le` goes from 1 to 0, the storage holds the effective A-side value sampled at the last system clock edge at which `ab_le` was still 1. Any later detected falling transition of `ab_clk` overwrites it.
- R5: `b_out_en` is 1 exactly when `ab_oe` is 1 (active high).
- R6: The B-to-A path behaves as R1 to R4 do, using `ba_le`, `ba_clk`, `b_in`/`b_ext_drv` as its source and `a_out` as its output.
- R7: `a_out_en` is 1 exactly when `ba_oe_n` is 0 (active low).
- R8: Each port keeper loads that port's input at every system clock edge at which the external drive flag (`a_ext_drv` or `b_ext_drv`) is 1. While the flag is 0, the path reads the keeper instead of the input.
- R9: A synchronous reset (`rst_n` low at a clock edge) clears both keepers and both storage elements to zero. With both latch enables low, both data outputs then read zero.
- R10: Storage and data outputs keep working while a drive enable is inactive. The data vector stays valid, and only the enable bit shows that the port is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 18 | Value seen on the A bus |
| a_ext_drv | input | 1 | 1 when an external device drives the A bus |
| b_in | input | 18 | Value seen on the B bus |
| b_ext_drv | input | 1 | 1 when an external device drives the B bus |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_clk | input | 1 | A-to-B capture strobe; loads on a falling transition |
| ab_oe | input | 1 | A-to-B drive enable, active high |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_clk | input | 1 | B-to-A capture strobe; loads on a falling transition |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| b_out | output | 18 | Data to drive onto the B bus |
| b_out_en | output | 1 | 1 when the B bus should be driven |
| a_out | output | 18 | Data to drive onto the A bus |
| a_out_en | output | 1 | 1 when the A bus should be driven |

## Verification
Drive enables and transparent data are combinational, so they are due in the same cycle as the input change. A strobe capture or a keeper load is due one system clock edge after the edge at which it was sampled. A strobe's falling transition itself spans two edges: one edge sees it high and the next sees it low. The bench changes inputs at the falling system clock edge and compares all four outputs at the following falling edge, before driving anything new. Each comparison therefore sees exactly one rising edge of register updates, and the reference model in the bench advances on that same edge.

// File: rtl/xcvr_pkg.sv
// Package: shared width and mode type for the bidirectional transceiver.
// Assumes: one system clock domain for all storage.
package xcvr_pkg;
    localparam int XCVR_W = 18;

    // Operating mode of one direction's storage element.
    typedef enum logic [1:0] {
        MODE_HOLD   = 2'd0,
        MODE_PASS   = 2'd1,
        MODE_STROBE = 2'd2
    } path_mode_e;
endpackage

// File: rtl/bus_keeper.sv
// Module: bus_keeper
// Models bus-hold on one port. The keeper register loads the port
// value while an external device drives it. The effective value
// handed to the data path is the live input when driven and the kept
// value when the bus floats.
// Assumes: drv and bus_in are synchronous to clk.
module bus_keeper #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drv,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] eff
);
    logic [W-1:0] held_q;

    // Keeper register: follow the bus while it is driven, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (drv) begin
            held_q <= bus_in;
        end
    end

    // Effective bus value: live input when driven, kept value otherwise.
    always_comb begin
        eff = drv ? bus_in : held_q;
    end
endmodule

// File: rtl/path_store.sv
// Module: path_store
// One direction's storage. It is transparent while le is 1. While le
// is 0 it holds, and it reloads when a falling transition of the
// strobe dstrb is found between two clk edges.
// Assumes: dstrb is a level sampled on clk, not a clock.
module path_store
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         dstrb,
    input  logic [W-1:0] src,
    output logic [W-1:0] q_out
);
    logic         strb_prev_q;
    logic         strb_fall;
    logic [W-1:0] store_q;
    path_mode_e   mode;

    // Strobe history: sampled every edge, including during reset, so
    // the first edge after reset cannot report a false transition.
    always_ff @(posedge clk) begin
        strb_prev_q <= dstrb;
    end

    // Falling transition detect and mode decode.
    always_comb begin
        strb_fall = strb_prev_q & ~dstrb;
        if (le) begin
            mode = MODE_PASS;
        end else if (strb_fall) begin
            mode = MODE_STROBE;
        end else begin
            mode = MODE_HOLD;
        end
    end

    // Storage register: load in pass or strobe mode, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            case (mode)
                MODE_PASS, MODE_STROBE: store_q <= src;
                default:                store_q <= store_q;
            endcase
        end
    end

    // Output select: live source while transparent, stored word otherwise.
    always_comb begin
        q_out = le ? src : store_q;
    end
endmodule

// File: rtl/port_drive.sv
// Module: port_drive
// Turns a path result and its output-enable input into a data vector
// plus a drive-enable bit. The enable polarity is fixed by ACTIVE_LOW.
// Assumes: the tri-state pad, if any, lives outside this block.
module port_drive #(
    parameter int W          = 18,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic         oe,
    input  logic [W-1:0] d,
    output logic [W-1:0] dout,
    output logic         en
);
    // Data passes straight through; the enable carries the drive decision.
    always_comb begin
        dout = d;
    end

    generate
        if (ACTIVE_LOW) begin : g_low
            // Enable decode for an active-low control.
            always_comb begin
                en = ~oe;
            end
        end else begin : g_high
            // Enable decode for an active-high control.
            always_comb begin
                en = oe;
            end
        end
    endgenerate
endmodule

// File: rtl/bidir_bus_xcvr.sv
// Module: bidir_bus_xcvr (top)
// Two-port transceiver with independent A-to-B and B-to-A paths. Each
// path has a bus keeper on its source, a latch/strobe storage element
// and a drive-enable decode. A-to-B enable is active high, B-to-A is
// active low.
// Assumes: all inputs are synchronous to clk; reset is synchronous.
module bidir_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int WIDTH = XCVR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic             a_ext_drv,
    input  logic [WIDTH-1:0] b_in,
    input  logic             b_ext_drv,
    input  logic             ab_le,
    input  logic             ab_clk,
    input  logic             ab_oe,
    input  logic             ba_le,
    input  logic             ba_clk,
    input  logic             ba_oe_n,
    output logic [WIDTH-1:0] b_out,
    output logic             b_out_en,
    output logic [WIDTH-1:0] a_out,
    output logic             a_out_en
);
    localparam int NDIR = 2;

    logic [WIDTH-1:0] bus_val [NDIR];
    logic             bus_drv [NDIR];
    logic [WIDTH-1:0] eff_val [NDIR];
    logic             le_v    [NDIR];
    logic             strb_v  [NDIR];
    logic             oe_v    [NDIR];
    logic [WIDTH-1:0] res_v   [NDIR];
    logic [WIDTH-1:0] dout_v  [NDIR];
    logic             en_v    [NDIR];

    // Index 0 is the A-to-B path, index 1 the B-to-A path.
    always_comb begin
        bus_val[0] = a_in;    bus_drv[0] = a_ext_drv;
        bus_val[1] = b_in;    bus_drv[1] = b_ext_drv;
        le_v[0]    = ab_le;   strb_v[0]  = ab_clk;   oe_v[0] = ab_oe;
        le_v[1]    = ba_le;   strb_v[1]  = ba_clk;   oe_v[1] = ba_oe_n;
    end

    generate
        for (genvar d = 0; d < NDIR; d++) begin : g_dir
            bus_keeper #(.W(WIDTH)) u_keep (
                .clk    (clk),
                .rst_n  (rst_n),
                .drv    (bus_drv[d]),
                .bus_in (bus_val[d]),
                .eff    (eff_val[d])
            );

            path_store #(.W(WIDTH)) u_store (
                .clk   (clk),
                .rst_n (rst_n),
                .le    (le_v[d]),
                .dstrb (strb_v[d]),
                .src   (eff_val[d]),
                .q_out (res_v[d])
            );

            port_drive #(.W(WIDTH), .ACTIVE_LOW(d == 1)) u_drv (
                .oe   (oe_v[d]),
                .d    (res_v[d]),
                .dout (dout_v[d]),
                .en   (en_v[d])
            );
        end
    endgenerate

    // Map path results onto the far-side ports.
    always_comb begin
        b_out    = dout_v[0];
        b_out_en = en_v[0];
        a_out    = dout_v[1];
        a_out_en = en_v[1];
    end
endmodule

// File: rtl/bidir_bus_xcvr_chk.sv
// Module: bidir_bus_xcvr_chk
// Port-level properties for the transceiver, bound to the top module.
module bidir_bus_xcvr_chk #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic             a_ext_drv,
    input logic [WIDTH-1:0] b_in,
    input logic             b_ext_drv,
    input logic             ab_le,
    input logic             ab_clk,
    input logic             ab_oe,
    input logic             ba_le,
    input logic             ba_clk,
    input logic             ba_oe_n,
    input logic [WIDTH-1:0] b_out,
    input logic             b_out_en,
    input logic [WIDTH-1:0] a_out,
    input logic             a_out_en
);
    // R1: transparent A-to-B with a driven A bus
    a_r1_pass_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_le && a_ext_drv) |-> (b_out == a_in));

    // R2: no strobe fall with latch enable low keeps b_out steady
    a_r2_hold_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !($past(ab_clk) && !ab_clk)) |=> (ab_le || $stable(b_out)));

    // R3: strobe fall loads the driven A value
    a_r3_strobe_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && $past(ab_clk) && !ab_clk && a_ext_drv) |=> (ab_le || b_out == $past(a_in)));

    // R4: latch-enable fall keeps the last transparent value
    a_r4_le_fall_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_le && a_ext_drv) |=> (ab_le || ($past(ab_clk) && !ab_clk) || b_out == $past(a_in)));

    // R5: A-to-B enable is active high
    a_r5_oe_ab: assert property (@(posedge clk) disable iff (!rst_n)
        b_out_en == ab_oe);

    // R6: transparent B-to-A with a driven B bus
    a_r6_pass_ba: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_le && b_ext_drv) |-> (a_out == b_in));

    // R7: B-to-A enable is active low
    a_r7_oe_ba: assert property (@(posedge clk) disable iff (!rst_n)
        a_out_en == !ba_oe_n);

    // R8: A keeper supplies the last driven value when the bus floats
    a_r8_keep_a: assert property (@(posedge clk) disable iff (!rst_n)
        a_ext_drv |=> (a_ext_drv || !ab_le || b_out == $past(a_in)));
endmodule

bind bidir_bus_xcvr bidir_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_in      (a_in),
    .a_ext_drv (a_ext_drv),
    .b_in      (b_in),
    .b_ext_drv (b_ext_drv),
    .ab_le     (ab_le),
    .ab_clk    (ab_clk),
    .ab_oe     (ab_oe),
    .ba_le     (ba_le),
    .ba_clk    (ba_clk),
    .ba_oe_n   (ba_oe_n),
    .b_out     (b_out),
    .b_out_en  (b_out_en),
    .a_out     (a_out),
    .a_out_en  (a_out_en)
);

// File: tb/sim_bidir_bus_xcvr.sv
`timescale 1ns/1ps
module sim_bidir_bus_xcvr;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         a_ext_drv = 1'b0, b_ext_drv = 1'b0;
    logic         ab_le = 1'b0, ab_clk = 1'b0, ab_oe = 1'b0;
    logic         ba_le = 1'b0, ba_clk = 1'b0, ba_oe_n = 1'b1;
    logic [W-1:0] b_out, a_out;
    logic         b_out_en, a_out_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [W-1:0] m_keep_a = '0, m_keep_b = '0, m_st_ab = '0, m_st_ba = '0;
    logic         m_prev_ab = 1'b0, m_prev_ba = 1'b0;

    always #4 clk = ~clk;

    bidir_bus_xcvr #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_ext_drv(a_ext_drv),
        .b_in(b_in), .b_ext_drv(b_ext_drv),
        .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
        .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
        .b_out(b_out), .b_out_en(b_out_en),
        .a_out(a_out), .a_out_en(a_out_en)
    );

    function automatic logic [W-1:0] eff(input logic drv, input logic [W-1:0] v,
                                         input logic [W-1:0] k);
        return drv ? v : k;
    endfunction

    function automatic logic [W-1:0] exp_dout(input logic le, input logic [W-1:0] src,
                                              input logic [W-1:0] st);
        return le ? src : st;
    endfunction

    // Reference model advancing on the same edge as the design
    always @(posedge clk) begin
        m_prev_ab <= ab_clk;
        m_prev_ba <= ba_clk;
        if (!rst_n) begin
            m_keep_a <= '0; m_keep_b <= '0; m_st_ab <= '0; m_st_ba <= '0;
        end else begin
            if (a_ext_drv) m_keep_a <= a_in;
            if (b_ext_drv) m_keep_b <= b_in;
            if (ab_le || (m_prev_ab && !ab_clk)) m_st_ab <= eff(a_ext_drv, a_in, m_keep_a);
            if (ba_le || (m_prev_ba && !ba_clk)) m_st_ba <= eff(b_ext_drv, b_in, m_keep_b);
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model; call at a falling edge.
    task automatic check_all(input string tag_ab, input string tag_ba);
        chk(tag_ab, b_out, exp_dout(ab_le, eff(a_ext_drv, a_in, m_keep_a), m_st_ab));
        chk(tag_ba, a_out, exp_dout(ba_le, eff(b_ext_drv, b_in, m_keep_b), m_st_ba));
        chk("R5", {{(W-1){1'b0}}, b_out_en}, {{(W-1){1'b0}}, ab_oe});
        chk("R7", {{(W-1){1'b0}}, a_out_en}, {{(W-1){1'b0}}, !ba_oe_n});
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // Reset with inputs busy (R9)
        a_in = 18'h3ffff; b_in = 18'h2aaaa; a_ext_drv = 1; b_ext_drv = 1;
        repeat (3) cyc();
        a_ext_drv = 0; b_ext_drv = 0;
        @(negedge clk);
        rst_n = 1'b1;
        cyc();
        chk("R9", b_out, '0);
        chk("R9", a_out, '0);

        // R1 / R6 transparent, both directions at once
        a_ext_drv = 1; b_ext_drv = 1; a_in = 18'h12345; b_in = 18'h0abcd;
        ab_le = 1; ba_le = 1; ab_oe = 1; ba_oe_n = 0;
        #1;
        chk("R1", b_out, 18'h12345);
        chk("R6", a_out, 18'h0abcd);
        cyc();
        // R4: drop latch enable, change inputs; last transparent value is kept
        ab_le = 0; ba_le = 0; a_in = 18'h00f0f; b_in = 18'h3c3c3;
        cyc();
        chk("R4", b_out, 18'h12345);
        chk("R4", a_out, 18'h0abcd);
        // R3: strobe high then low loads new value
        ab_clk = 1; ba_clk = 1;
        cyc();
        chk("R2", b_out, 18'h12345);
        ab_clk = 0; ba_clk = 0;
        cyc();
        chk("R3", b_out, 18'h00f0f);
        chk("R6", a_out, 18'h3c3c3);
        // R10: outputs disabled, data path still works
        ab_oe = 0; ba_oe_n = 1; a_in = 18'h1beef;
        ab_clk = 1; cyc(); ab_clk = 0; cyc();
        chk("R10", b_out, 18'h1beef);
        chk("R5", {17'd0, b_out_en}, 18'd0);
        chk("R7", {17'd0, a_out_en}, 18'd0);
        // R8: bus floats, keeper value flows in transparent mode
        a_in = 18'h2d2d2; cyc();
        a_ext_drv = 0; a_in = 18'h00001; ab_le = 1;
        #1;
        chk("R8", b_out, 18'h2d2d2);
        cyc();

        // Constrained random phase
        for (int i = 0; i < 3000; i++) begin
            logic al, bl;
            al = ab_le; bl = ba_le;
            check_all(al ? "R1" : "R3", bl ? "R6" : "R6");
            a_in      = W'($urandom);
            b_in      = W'($urandom);
            a_ext_drv = ($urandom % 4) != 0;
            b_ext_drv = ($urandom % 4) != 0;
            ab_le     = ($urandom % 4) == 0;
            ba_le     = ($urandom % 4) == 0;
            ab_clk    = $urandom % 2;
            ba_clk    = $urandom % 2;
            ab_oe     = $urandom % 2;
            ba_oe_n   = $urandom % 2;
            if (i == 1500) rst_n = 1'b0;
            if (i == 1502) rst_n = 1'b1;
            cyc();
        end
        check_all("R2", "R6");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule